// File: doc/BRIEF.md
# Line-Following Wheel Command Controller

This block steers a two-wheel robot along a dark track line. A one-cycle button pulse toggles a run flag between stopped and running. While the flag is set, a steering state machine reads two line sensors, one under each side of the robot. It picks a drive pattern and issues a symbolic speed code for each wheel.

A decoder, kept apart from the steering logic, turns each speed code into a duty word for a downstream PWM stage. The steering logic therefore knows nothing about PWM resolution. A parameter selects which sensor level means "black", so sensors of either polarity can be used without an inverter outside the block.

Button debouncing, edge extraction and PWM generation sit outside the block.

Top module: `lfc_motor_ctrl`

## Requirements
- R1: While reset is low, and at the first sample after it, `run_o` is 0, both speed codes are 0 and both duty words are 0.
- R2: A high `btn_pulse_i` at a rising clock edge inverts `run_o` at that edge. With the pulse low, `run_o` holds its value.
- R3: Speed codes are 2-bit values: 0 = stop, 1 = slow (15%), 2 = half (50%), 3 = fast (90%). A clock edge at which `run_o` is 0 sets both codes to 0.
- R4: At an edge where `run_o` is 1 and neither sensor reads black, both codes become 2.
- R5: At an edge where `run_o` is 1 and only the left sensor reads black, the left code becomes 3 and the right code becomes 1.
- R6: At an edge where `run_o` is 1 and only the right sensor reads black, the right code becomes 3 and the left code becomes 1.
- R7: At an edge where `run_o` is 1 and both sensors read black, the line counts as lost. Both codes become 0 and `run_o` is not changed by this.
- R8: A sensor reads black when its level equals the parameter `BLACK_LEVEL`, which defaults to 1.
- R9: With `DUTY_W` = 8, each duty word follows its code in the same cycle: code 0 gives 0, code 1 gives 38, code 2 gives 128 and code 3 gives 230.
- R10: The steering machine uses the `run_o` value held before the edge. A button pulse therefore reaches the wheel codes one cycle after it reaches `run_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_pulse_i | input | 1 | One-cycle start/stop request |
| sense_left_i | input | 1 | Left line sensor level |
| sense_right_i | input | 1 | Right line sensor level |
| run_o | output | 1 | Running flag |
| code_left_o | output | 2 | Left wheel speed code |
| code_right_o | output | 2 | Right wheel speed code |
| duty_left_o | output | DUTY_W | Left wheel duty word |
| duty_right_o | output | DUTY_W | Right wheel duty word |

## Verification
The bench builds two copies of the block, both with 8-bit duty words. One uses the default black level of 1. The other uses a black level of 0 and receives inverted sensor levels. Both copies must produce identical commands, so the polarity variant is tested against the same expected values. The 8-bit width puts the rounded duty values 38, 128 and 230 within reach of exact comparison. Random button pulses interleaved with sensor patterns reach the stop-to-run transitions, the lost-line case and the one-cycle lag between the flag and the wheel codes.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

   typedef enum logic [1:0] {
      SPD_STOP = 2'd0,
      SPD_SLOW = 2'd1,
      SPD_HALF = 2'd2,
      SPD_FAST = 2'd3
   } speed_code_t;

   typedef enum logic [1:0] {
      ST_PARK  = 2'd0,
      ST_AHEAD = 2'd1,
      ST_VEERL = 2'd2,
      ST_VEERR = 2'd3
   } steer_state_t;

   // percentage of full scale, rounded half up
   function automatic int unsigned pct_to_duty(input int unsigned pct,
                                               input int unsigned width);
      int unsigned full;
      full = (1 << width) - 1;
      return (pct * full + 50) / 100;
   endfunction

endpackage

// File: rtl/lfc_run_toggle.sv
module lfc_run_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_pulse_i,
   output logic run_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_o <= 1'b0;
      else if (btn_pulse_i) run_o <= ~run_o;
   end

   a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      btn_pulse_i |=> run_o != $past(run_o));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !btn_pulse_i |=> $stable(run_o));

endmodule

// File: rtl/lfc_steer_fsm.sv
module lfc_steer_fsm
   import lfc_pkg::*;
#(
   parameter logic BLACK_LEVEL = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run_i,
   input  logic        sense_left_i,
   input  logic        sense_right_i,
   output speed_code_t code_left_o,
   output speed_code_t code_right_o
);

   logic         blk_l, blk_r;
   steer_state_t state_q, state_d;

   generate
      if (BLACK_LEVEL) begin : g_pol_high
         assign blk_l = sense_left_i;
         assign blk_r = sense_right_i;
      end else begin : g_pol_low
         assign blk_l = ~sense_left_i;
         assign blk_r = ~sense_right_i;
      end
   endgenerate

   always_comb begin
      state_d = ST_PARK;
      if (run_i) begin
         unique case ({blk_l, blk_r})
            2'b00:   state_d = ST_AHEAD;
            2'b10:   state_d = ST_VEERL;
            2'b01:   state_d = ST_VEERR;
            default: state_d = ST_PARK;   // line lost: hold still
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_PARK;
      else        state_q <= state_d;
   end

   always_comb begin
      unique case (state_q)
         ST_AHEAD: begin code_left_o = SPD_HALF; code_right_o = SPD_HALF; end
         ST_VEERL: begin code_left_o = SPD_FAST; code_right_o = SPD_SLOW; end
         ST_VEERR: begin code_left_o = SPD_SLOW; code_right_o = SPD_FAST; end
         default:  begin code_left_o = SPD_STOP; code_right_o = SPD_STOP; end
      endcase
   end

   a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (code_left_o == SPD_STOP && code_right_o == SPD_STOP));

   a_r4_straight: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !blk_l && !blk_r) |=> (code_left_o == SPD_HALF && code_right_o == SPD_HALF));

   a_r5_veer_left: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && blk_l && !blk_r) |=> (code_left_o == SPD_FAST && code_right_o == SPD_SLOW));

   a_r6_veer_right: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !blk_l && blk_r) |=> (code_left_o == SPD_SLOW && code_right_o == SPD_FAST));

   a_r7_lost: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && blk_l && blk_r) |=> (code_left_o == SPD_STOP && code_right_o == SPD_STOP));

endmodule

// File: rtl/lfc_duty_decode.sv
module lfc_duty_decode
   import lfc_pkg::*;
#(
   parameter int unsigned DUTY_W   = 8,
   parameter int unsigned PCT_SLOW = 15,
   parameter int unsigned PCT_HALF = 50,
   parameter int unsigned PCT_FAST = 90
) (
   input  speed_code_t       code_i,
   output logic [DUTY_W-1:0] duty_o
);

   localparam logic [DUTY_W-1:0] D_SLOW = DUTY_W'(pct_to_duty(PCT_SLOW, DUTY_W));
   localparam logic [DUTY_W-1:0] D_HALF = DUTY_W'(pct_to_duty(PCT_HALF, DUTY_W));
   localparam logic [DUTY_W-1:0] D_FAST = DUTY_W'(pct_to_duty(PCT_FAST, DUTY_W));

   generate
      if (PCT_SLOW > PCT_HALF || PCT_HALF > PCT_FAST || PCT_FAST > 100) begin : g_bad_pct
         $error("speed percentages must rise and stay within 100");
      end
   endgenerate

   always_comb begin
      unique case (code_i)
         SPD_SLOW: duty_o = D_SLOW;
         SPD_HALF: duty_o = D_HALF;
         SPD_FAST: duty_o = D_FAST;
         default:  duty_o = '0;
      endcase
   end

   always_comb begin
      if (code_i == SPD_STOP)
         a_r9_stop_zero: assert (duty_o == '0);
   end

endmodule

// File: rtl/lfc_motor_ctrl.sv
module lfc_motor_ctrl
   import lfc_pkg::*;
#(
   parameter int unsigned DUTY_W      = 8,
   parameter logic        BLACK_LEVEL = 1'b1,
   parameter int unsigned PCT_SLOW    = 15,
   parameter int unsigned PCT_HALF    = 50,
   parameter int unsigned PCT_FAST    = 90
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_pulse_i,
   input  logic              sense_left_i,
   input  logic              sense_right_i,
   output logic              run_o,
   output logic [1:0]        code_left_o,
   output logic [1:0]        code_right_o,
   output logic [DUTY_W-1:0] duty_left_o,
   output logic [DUTY_W-1:0] duty_right_o
);

   localparam int unsigned N_WHEEL = 2;

   generate
      if (DUTY_W < 4 || DUTY_W > 16) begin : g_bad_width
         $error("DUTY_W must lie between 4 and 16");
      end
   endgenerate

   logic                     run_q;
   speed_code_t              code_l, code_r;
   speed_code_t              codes [N_WHEEL];
   logic [DUTY_W-1:0]        duties [N_WHEEL];

   lfc_run_toggle u_toggle (
      .clk         (clk),
      .rst_n       (rst_n),
      .btn_pulse_i (btn_pulse_i),
      .run_o       (run_q)
   );

   lfc_steer_fsm #(.BLACK_LEVEL(BLACK_LEVEL)) u_steer (
      .clk           (clk),
      .rst_n         (rst_n),
      .run_i         (run_q),
      .sense_left_i  (sense_left_i),
      .sense_right_i (sense_right_i),
      .code_left_o   (code_l),
      .code_right_o  (code_r)
   );

   assign codes[0] = code_l;
   assign codes[1] = code_r;

   generate
      for (genvar w = 0; w < N_WHEEL; w++) begin : g_wheel
         lfc_duty_decode #(
            .DUTY_W  (DUTY_W),
            .PCT_SLOW(PCT_SLOW),
            .PCT_HALF(PCT_HALF),
            .PCT_FAST(PCT_FAST)
         ) u_dec (
            .code_i (codes[w]),
            .duty_o (duties[w])
         );
      end
   endgenerate

   assign run_o        = run_q;
   assign code_left_o  = code_l;
   assign code_right_o = code_r;
   assign duty_left_o  = duties[0];
   assign duty_right_o = duties[1];

   // R10: wheel codes follow the flag value from before the edge
   a_r10_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && btn_pulse_i) |=> (run_o && code_left_o == 2'd0 && code_right_o == 2'd0));

endmodule

// File: tb/lfc_motor_ctrl_test.sv
module lfc_motor_ctrl_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn = 1'b0;
   logic sl = 1'b0, sr = 1'b0;

   logic       run_a, run_b;
   logic [1:0] cl_a, cr_a, cl_b, cr_b;
   logic [7:0] dl_a, dr_a, dl_b, dr_b;

   int checks = 0;
   int errors = 0;

   logic       m_run = 1'b0;
   logic [1:0] m_cl = 2'd0, m_cr = 2'd0;

   always #10 clk = ~clk;   // 50 MHz

   lfc_motor_ctrl #(.DUTY_W(8), .BLACK_LEVEL(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .btn_pulse_i(btn),
      .sense_left_i(sl), .sense_right_i(sr),
      .run_o(run_a), .code_left_o(cl_a), .code_right_o(cr_a),
      .duty_left_o(dl_a), .duty_right_o(dr_a));

   lfc_motor_ctrl #(.DUTY_W(8), .BLACK_LEVEL(1'b0)) uut_inv (
      .clk(clk), .rst_n(rst_n), .btn_pulse_i(btn),
      .sense_left_i(~sl), .sense_right_i(~sr),
      .run_o(run_b), .code_left_o(cl_b), .code_right_o(cr_b),
      .duty_left_o(dl_b), .duty_right_o(dr_b));

   function automatic logic [7:0] exp_duty(input logic [1:0] c);
      case (c)
         2'd1:    return 8'd38;
         2'd2:    return 8'd128;
         2'd3:    return 8'd230;
         default: return 8'd0;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string tag_for(input logic run, input logic l, input logic r);
      if (!run)       return "R3/R10";
      if (!l && !r)   return "R4";
      if (l && !r)    return "R5";
      if (!l && r)    return "R6";
      return "R7";
   endfunction

   task automatic check_all(input string req);
      chk({req, " R2 run"}, run_a, m_run);
      chk({req, " left code"}, cl_a, m_cl);
      chk({req, " right code"}, cr_a, m_cr);
      chk("R9 left duty", dl_a, exp_duty(m_cl));
      chk("R9 right duty", dr_a, exp_duty(m_cr));
      chk("R8 inv run", run_b, m_run);
      chk("R8 inv left code", cl_b, m_cl);
      chk("R8 inv right code", cr_b, m_cr);
      chk("R8 inv left duty", dl_b, exp_duty(m_cl));
      chk("R8 inv right duty", dr_b, exp_duty(m_cr));
   endtask

   // called at a falling edge: drive, model the rising edge, check at next falling edge
   task automatic step(input logic b, input logic l, input logic r);
      string req;
      btn = b; sl = l; sr = r;
      req = tag_for(m_run, l, r);
      @(posedge clk);
      if (!m_run)          begin m_cl = 2'd0; m_cr = 2'd0; end
      else if (!l && !r)   begin m_cl = 2'd2; m_cr = 2'd2; end
      else if (l && !r)    begin m_cl = 2'd3; m_cr = 2'd1; end
      else if (!l && r)    begin m_cl = 2'd1; m_cr = 2'd3; end
      else                 begin m_cl = 2'd0; m_cr = 2'd0; end
      m_run = m_run ^ b;
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset");

      // stopped: sensors must not move wheels
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      // start: flag rises, wheels still stopped this cycle (R10)
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);   // R4
      step(1'b0, 1'b1, 1'b0);   // R5
      step(1'b0, 1'b0, 1'b1);   // R6
      step(1'b0, 1'b1, 1'b1);   // R7 lost line, still running
      step(1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b0, 1'b0);   // recovers
      // stop while on a turn: one more cycle of motion, then stop (R10, R3)
      step(1'b1, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      // back-to-back pulses
      step(1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);

      for (int i = 0; i < 400; i++) begin
         logic b;
         b = ($urandom % 8) == 0;
         step(b, 1'($urandom), 1'($urandom));
      end

      // reset in mid-run returns all outputs to zero (R1)
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      rst_n = 1'b0;
      m_run = 1'b0; m_cl = 2'd0; m_cr = 2'd0;
      @(negedge clk);
      check_all("R1 reset mid-run");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule